// File: doc/BRIEF.md
# Serial Peripheral Slave Channel

This block is one serial slave channel. An external master supplies the serial clock and an active-low select. All serial inputs are brought into the local clock domain through a short synchronizer, and edges of the serial clock are detected there. Words are shifted most significant bit first in both directions. The word length runs from 1 to `DATA_W` bits, and clock polarity and phase are configurable.

The host side is a plain strobe interface. It has one write strobe for the configuration word, one write strobe for the transmit holding register, and one read strobe that consumes the receive holding register. Two level outputs, transmit-empty and receive-full, serve as interrupt and status lines. Three one-cycle event pulses report a stale transmit word, a lost receive word and a finished word. Two request lines let a DMA engine refill the transmit register or drain the receive register.

A stale transmit word never stalls the link: it is simply sent again and reported. In transmit-only operation the whole receive side stays silent.

Top module: `spis_slave`

## Requirements
- R1: After reset, `tx_empty` is 1, and `rx_full`, both DMA request lines, all three event pulses and `spi_miso_oe` are 0.
- R2: With mode bits `cfg[2:1]` = 2'b00 (transmit-and-receive), each word of `cfg[8:5]`+1 bits is shifted MSB first on `spi_miso` and `spi_mosi`. When the last bit is sampled, `evt_eot` pulses for one cycle, the received word appears on `rx_data` and `rx_full` is set in that same cycle.
- R3: The leading edge is the serial clock transition away from the idle level `cfg[4]`. With `cfg[3]`=0 both sides sample on leading edges and change data on trailing edges. With `cfg[3]`=1 they change data on leading edges and sample on trailing edges.
- R4: At the first leading edge of every word, the transmit holding register is copied into the shifter. If the register was not written since the previous copy, `evt_tx_underflow` pulses and the old word is sent unchanged.
- R5: If a word completes while `rx_full` is 1 and `rx_rd` is not asserted in that cycle, `evt_rx_overflow` pulses and the new word replaces the old one. If `rx_rd` coincides with completion, no overflow is reported and `rx_full` stays 1.
- R6: With mode bit `cfg[2]`=1 (transmit-only, e.g. 2'b10), words are still sent and `evt_eot` still pulses. `rx_data` is not updated, and `rx_full`, `evt_rx_overflow` and `dma_rd_req` stay 0.
- R7: `dma_wr_req` equals enable (`cfg[0]`) AND `cfg[10]` AND `tx_empty`. `dma_rd_req` equals enable AND `cfg[9]` AND `rx_full`.
- R8: While the channel is enabled, a configuration write changes only the enable bit `cfg[0]`. The clock-divider field `cfg[14:11]` has no effect on transfers.
- R9: Raising `spi_cs_n` before a word's last bit aborts that word: no `evt_eot` and no receive update. The next word restarts at its first bit.
- R10: `spi_miso_oe` is 1 only while enabled with `spi_cs_n` low. `tx_empty` clears on a transmit write and sets again when the word is copied into the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 15 | Configuration word: en[0], mode[2:1], phase[3], polarity[4], length-1[8:5], rd-DMA en[9], wr-DMA en[10], divider[14:11] |
| tx_we | input | 1 | Transmit holding register write strobe |
| tx_wdata | input | DATA_W | Transmit word |
| rx_rd | input | 1 | Receive holding register read strobe |
| rx_data | output | DATA_W | Receive holding register |
| tx_empty | output | 1 | Transmit register not refreshed since the last copy |
| rx_full | output | 1 | Unread receive word present |
| evt_tx_underflow | output | 1 | Stale transmit word sent (pulse) |
| evt_rx_overflow | output | 1 | Unread receive word overwritten (pulse) |
| evt_eot | output | 1 | Word completed (pulse) |
| dma_rd_req | output | 1 | DMA request to drain the receive register |
| dma_wr_req | output | 1 | DMA request to refill the transmit register |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |

## Verification
Word completion and a host read of the receive register can land in the same clock cycle. When they do, the read consumes the old word and the new word must arrive without an overflow report. The bench provokes this by counting the synchronizer stages after it drives the last sampling edge, so that the `rx_rd` strobe meets the completion cycle exactly. It then expects `rx_full` still set, the new data on `rx_data` and no `evt_rx_overflow` pulse. It also runs the contrasting case, completion with no read while the register is full, and expects the overflow pulse there.

// File: rtl/spis_pkg.sv
package spis_pkg;

    localparam int LEN_W = 4;

    typedef enum logic [1:0] {
        MODE_TXRX   = 2'b00,
        MODE_TXONLY = 2'b10
    } xfer_mode_e;

    typedef struct packed {
        logic [3:0]       clkdiv;
        logic             dmaw_en;
        logic             dmar_en;
        logic [LEN_W-1:0] wlen;
        logic             pol;
        logic             pha;
        logic [1:0]       mode;
        logic             en;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    function automatic logic is_tx_only(input logic [1:0] mode);
        return mode[1];
    endfunction

    function automatic cfg_t cfg_merge(input cfg_t cur, input cfg_t wr);
        cfg_t res;
        if (cur.en) begin
            res    = cur;
            res.en = wr.en;
        end else begin
            res = wr;
        end
        return res;
    endfunction

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= RST_VAL;
                else     chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= RST_VAL;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spis_engine.sv
module spis_engine
    import spis_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              pha,
    input  logic              pol,
    input  logic [LEN_W-1:0]  wlen,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] tx_word,
    output logic              miso,
    output logic              load_ev,
    output logic              done_ev,
    output logic [DATA_W-1:0] rx_word
);
    localparam logic [LEN_W-1:0] LAST_MAX = LEN_W'(DATA_W - 1);

    logic              sclk_q;
    logic              need_load;
    logic [LEN_W-1:0]  cnt;
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] rx_sh;
    logic [LEN_W-1:0]  last;
    logic              active, toggled, lead, trail, samp, shft;

    assign last    = (wlen > LAST_MAX) ? LAST_MAX : wlen;
    assign active  = en & ~cs_n_s;
    assign toggled = sclk_s ^ sclk_q;
    assign lead    = active & toggled & (sclk_s != pol);
    assign trail   = active & toggled & (sclk_s == pol);
    assign samp    = pha ? trail : lead;
    assign shft    = pha ? lead : trail;
    assign load_ev = lead & need_load;
    assign done_ev = samp & (cnt == last);
    assign rx_word = {rx_sh[DATA_W-2:0], mosi_s};
    assign miso    = need_load ? tx_word[last] : sh[last];

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            need_load <= 1'b1;
            sh        <= '0;
            rx_sh     <= '0;
        end else if (!active) begin
            cnt       <= '0;
            need_load <= 1'b1;
            rx_sh     <= '0;
        end else begin
            if (load_ev) begin
                sh        <= tx_word;
                need_load <= 1'b0;
            end else if (shft) begin
                sh <= sh << 1;
            end
            if (samp) begin
                if (done_ev) begin
                    cnt       <= '0;
                    rx_sh     <= '0;
                    need_load <= 1'b1;
                end else begin
                    cnt   <= cnt + 1'b1;
                    rx_sh <= rx_word;
                end
            end
        end
    end
endmodule

// File: rtl/spis_slave.sv
module spis_slave
    import spis_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [14:0]       cfg_wdata,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              evt_tx_underflow,
    output logic              evt_rx_overflow,
    output logic              evt_eot,
    output logic              dma_rd_req,
    output logic              dma_wr_req,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe
);
    cfg_t              cfg_q;
    logic [DATA_W-1:0] tx_hold;
    logic              tx_fresh;
    logic [DATA_W-1:0] rx_hold;
    logic              rx_full_q;
    logic              sclk_s, cs_n_s, mosi_s;
    logic              load_ev, done_ev;
    logic [DATA_W-1:0] rx_word;
    logic              rx_path;

    spis_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_sclk, spi_cs_n, spi_mosi}),
        .q   ({sclk_s, cs_n_s, mosi_s})
    );

    spis_engine #(.DATA_W(DATA_W)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .en      (cfg_q.en),
        .pha     (cfg_q.pha),
        .pol     (cfg_q.pol),
        .wlen    (cfg_q.wlen),
        .sclk_s  (sclk_s),
        .cs_n_s  (cs_n_s),
        .mosi_s  (mosi_s),
        .tx_word (tx_hold),
        .miso    (spi_miso),
        .load_ev (load_ev),
        .done_ev (done_ev),
        .rx_word (rx_word)
    );

    assign rx_path = ~is_tx_only(cfg_q.mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q            <= '0;
            tx_hold          <= '0;
            tx_fresh         <= 1'b0;
            rx_hold          <= '0;
            rx_full_q        <= 1'b0;
            evt_tx_underflow <= 1'b0;
            evt_rx_overflow  <= 1'b0;
            evt_eot          <= 1'b0;
        end else begin
            if (cfg_we) cfg_q <= cfg_merge(cfg_q, cfg_t'(cfg_wdata));
            if (tx_we)  tx_hold <= tx_wdata;

            if (load_ev)    tx_fresh <= tx_we;
            else if (tx_we) tx_fresh <= 1'b1;

            evt_tx_underflow <= load_ev & ~tx_fresh;
            evt_eot          <= done_ev;
            evt_rx_overflow  <= done_ev & rx_path & rx_full_q & ~rx_rd;

            if (done_ev && rx_path) begin
                rx_hold   <= rx_word;
                rx_full_q <= 1'b1;
            end else if (rx_rd) begin
                rx_full_q <= 1'b0;
            end
        end
    end

    assign rx_data     = rx_hold;
    assign rx_full     = rx_full_q;
    assign tx_empty    = ~tx_fresh;
    assign dma_rd_req  = cfg_q.en & cfg_q.dmar_en & rx_full_q & rx_path;
    assign dma_wr_req  = cfg_q.en & cfg_q.dmaw_en & ~tx_fresh;
    assign spi_miso_oe = cfg_q.en & ~cs_n_s;
endmodule

// File: rtl/spis_checker.sv
module spis_checker #(
    parameter int CFG_W = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             evt_eot,
    input logic             evt_rx_overflow,
    input logic             evt_tx_underflow,
    input logic             rx_full,
    input logic             tx_empty,
    input logic             dma_rd_req,
    input logic             dma_wr_req,
    input logic [CFG_W-1:0] cfg
);
    assert_eot_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        evt_eot |=> !evt_eot);

    assert_stale_only_R4: assert property (@(posedge clk) disable iff (rst)
        evt_tx_underflow |-> $past(tx_empty));

    assert_ovf_on_eot_R5: assert property (@(posedge clk) disable iff (rst)
        evt_rx_overflow |-> (evt_eot && rx_full));

    assert_txonly_no_fill_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> !$past(cfg[2]));

    assert_dma_rd_R7: assert property (@(posedge clk) disable iff (rst)
        dma_rd_req |-> rx_full);

    assert_dma_wr_R7: assert property (@(posedge clk) disable iff (rst)
        dma_wr_req |-> tx_empty);

    assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (rst)
        $past(cfg[0]) |-> (cfg[CFG_W-1:1] == $past(cfg[CFG_W-1:1])));
endmodule

bind spis_slave spis_checker #(.CFG_W(spis_pkg::CFG_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .evt_eot          (evt_eot),
    .evt_rx_overflow  (evt_rx_overflow),
    .evt_tx_underflow (evt_tx_underflow),
    .rx_full          (rx_full),
    .tx_empty         (tx_empty),
    .dma_rd_req       (dma_rd_req),
    .dma_wr_req       (dma_wr_req),
    .cfg              (cfg_q)
);

// File: tb/tb_spis_slave.sv
module tb_spis_slave;
    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [14:0] cfg_wdata = '0;
    logic        tx_we = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic        rx_rd = 1'b0;
    logic [15:0] rx_data;
    logic        tx_empty, rx_full, evt_tx_underflow, evt_rx_overflow, evt_eot;
    logic        dma_rd_req, dma_wr_req;
    logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe;

    spis_slave dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_data(rx_data),
        .tx_empty(tx_empty), .rx_full(rx_full),
        .evt_tx_underflow(evt_tx_underflow), .evt_rx_overflow(evt_rx_overflow),
        .evt_eot(evt_eot), .dma_rd_req(dma_rd_req), .dma_wr_req(dma_wr_req),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [15:0] d;
        bit          ovf;
        bit          full;
    } exp_t;
    exp_t exp_q[$];

    int n_chk = 0, n_fail = 0;
    int n_unf = 0, n_ovf = 0, n_eot = 0;
    bit pha_b = 1'b0, pol_b = 1'b0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: counts event pulses and scores completed words
    always @(negedge clk) begin
        if (!rst) begin
            if (evt_tx_underflow) n_unf++;
            if (evt_rx_overflow)  n_ovf++;
            if (evt_eot) begin
                exp_t e;
                n_eot++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected eot", 32'(evt_eot), 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    check(rx_data == e.d, "R2/R6 rx_data", 32'(rx_data), 32'(e.d));
                    check(evt_rx_overflow == e.ovf, "R5 overflow", 32'(evt_rx_overflow), 32'(e.ovf));
                    check(rx_full == e.full, "R2/R6 rx_full", 32'(rx_full), 32'(e.full));
                end
            end
        end
    end

    task automatic wait_h(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [14:0] mkcfg(input bit en, input logic [1:0] mode, input bit pha,
                                          input bit pol, input logic [3:0] wlen, input bit dmar,
                                          input bit dmaw, input logic [3:0] div);
        return {div, dmaw, dmar, wlen, pol, pha, mode, en};
    endfunction

    task automatic cfg_write(input logic [14:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic tx_write(input logic [15:0] v);
        @(negedge clk); tx_we = 1'b1; tx_wdata = v;
        @(negedge clk); tx_we = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic cs_low();
        @(negedge clk); spi_sclk = pol_b;
        wait_h(H); spi_cs_n = 1'b0;
        wait_h(H);
    endtask

    task automatic cs_high();
        wait_h(H); spi_cs_n = 1'b1;
        wait_h(H);
    endtask

    task automatic after_sample_edge(input bit rd_end);
        if (rd_end) begin
            @(posedge clk); @(posedge clk);
            @(negedge clk); rx_rd = 1'b1;
            @(negedge clk); rx_rd = 1'b0;
            wait_h(H - 2);
        end else begin
            wait_h(H);
        end
    endtask

    task automatic word(input logic [15:0] mo, input int nb, input bit rd_end, output logic [15:0] mi);
        mi = '0;
        for (int i = nb - 1; i >= 0; i--) begin
            if (!pha_b) begin
                spi_mosi = mo[i];
                wait_h(H);
                mi = {mi[14:0], spi_miso};
                spi_sclk = ~pol_b;
                after_sample_edge(rd_end && i == 0);
                spi_sclk = pol_b;
            end else begin
                spi_sclk = ~pol_b;
                spi_mosi = mo[i];
                wait_h(H);
                mi = {mi[14:0], spi_miso};
                spi_sclk = pol_b;
                after_sample_edge(rd_end && i == 0);
            end
        end
    endtask

    task automatic push(input logic [15:0] d, input bit ovf, input bit full);
        exp_t e;
        e.d = d; e.ovf = ovf; e.full = full;
        exp_q.push_back(e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] mi;
        int u0, o0, e0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(tx_empty == 1'b1, "R1 tx_empty", 32'(tx_empty), 1);
        check(rx_full == 1'b0, "R1 rx_full", 32'(rx_full), 0);
        check({dma_rd_req, dma_wr_req} == 2'b00, "R1 dma", 32'({dma_rd_req, dma_wr_req}), 0);
        check({evt_eot, evt_rx_overflow, evt_tx_underflow} == 3'b000, "R1 events", 32'({evt_eot, evt_rx_overflow, evt_tx_underflow}), 0);
        check(spi_miso_oe == 1'b0, "R1 miso_oe", 32'(spi_miso_oe), 0);

        // R2/R3/R7/R8 basic transmit-and-receive, divider field set (no effect)
        cfg_write(mkcfg(1, 2'b00, 0, 0, 4'd7, 1, 1, 4'd9));
        @(negedge clk);
        check(dma_wr_req == 1'b1, "R7 dma_wr on empty", 32'(dma_wr_req), 1);
        tx_write(16'h00A5);
        @(negedge clk);
        check(tx_empty == 1'b0, "R10 tx_empty clears", 32'(tx_empty), 0);
        check(dma_wr_req == 1'b0, "R7 dma_wr drops", 32'(dma_wr_req), 0);
        u0 = n_unf;
        cs_low();
        check(spi_miso_oe == 1'b1, "R10 miso_oe selected", 32'(spi_miso_oe), 1);
        push(16'h003C, 0, 1);
        word(16'h003C, 8, 0, mi);
        check(mi[7:0] == 8'hA5, "R2 miso word", 32'(mi[7:0]), 32'hA5);
        cs_high();
        check(n_unf == u0, "R4 no underflow on fresh", n_unf - u0, 0);
        check(dma_rd_req == 1'b1, "R7 dma_rd", 32'(dma_rd_req), 1);
        check(tx_empty == 1'b1, "R10 tx_empty after load", 32'(tx_empty), 1);

        // R4 stale word, R5 overflow
        u0 = n_unf;
        cs_low();
        push(16'h0055, 1, 1);
        word(16'h0055, 8, 0, mi);
        cs_high();
        check(mi[7:0] == 8'hA5, "R4 stale word resent", 32'(mi[7:0]), 32'hA5);
        check(n_unf == u0 + 1, "R4 underflow count", n_unf - u0, 1);
        host_read();
        @(negedge clk);
        check(rx_full == 1'b0, "R2 rx_full cleared by read", 32'(rx_full), 0);
        check(dma_rd_req == 1'b0, "R7 dma_rd drops", 32'(dma_rd_req), 0);

        // R5 read coinciding with completion; two words in one frame
        tx_write(16'h000F);
        u0 = n_unf; o0 = n_ovf;
        cs_low();
        push(16'h0011, 0, 1);
        word(16'h0011, 8, 0, mi);
        check(mi[7:0] == 8'h0F, "R2 first word", 32'(mi[7:0]), 32'h0F);
        push(16'h0099, 0, 1);
        word(16'h0099, 8, 1, mi);
        check(mi[7:0] == 8'h0F, "R4 second word stale", 32'(mi[7:0]), 32'h0F);
        cs_high();
        check(n_ovf == o0, "R5 no overflow with coincident read", n_ovf - o0, 0);
        check(n_unf == u0 + 1, "R4 underflow in frame", n_unf - u0, 1);
        host_read();

        // R4 refreshed words back to back
        u0 = n_unf;
        cs_low();
        tx_write(16'h00C3);
        push(16'h0000, 0, 1);
        word(16'h0000, 8, 0, mi);
        check(mi[7:0] == 8'hC3, "R4 refreshed word 1", 32'(mi[7:0]), 32'hC3);
        tx_write(16'h003E);
        push(16'h00FF, 1, 1);
        word(16'h00FF, 8, 0, mi);
        check(mi[7:0] == 8'h3E, "R4 refreshed word 2", 32'(mi[7:0]), 32'h3E);
        cs_high();
        check(n_unf == u0, "R4 no underflow when refreshed", n_unf - u0, 0);
        host_read();

        // R8 configuration write while enabled is ignored
        cfg_write(mkcfg(1, 2'b10, 1, 1, 4'd3, 0, 0, 4'd2));
        tx_write(16'h0081);
        cs_low();
        push(16'h007E, 0, 1);
        word(16'h007E, 8, 0, mi);
        cs_high();
        check(mi[7:0] == 8'h81, "R8 cfg unchanged while enabled", 32'(mi[7:0]), 32'h81);
        host_read();

        // R10/R7 disabled channel
        cfg_write(15'd0);
        cs_low();
        check(spi_miso_oe == 1'b0, "R10 miso_oe disabled", 32'(spi_miso_oe), 0);
        check(dma_wr_req == 1'b0, "R7 dma_wr disabled", 32'(dma_wr_req), 0);
        cs_high();

        // R3 phase 1, polarity 1, 12-bit words
        cfg_write(mkcfg(1, 2'b00, 1, 1, 4'd11, 1, 0, 4'd0));
        pha_b = 1'b1; pol_b = 1'b1;
        @(negedge clk);
        check(dma_wr_req == 1'b0, "R7 dma_wr enable bit off", 32'(dma_wr_req), 0);
        tx_write(16'h0ABC);
        cs_low();
        push(16'h05A3, 0, 1);
        word(16'h05A3, 12, 0, mi);
        cs_high();
        check(mi[11:0] == 12'hABC, "R3 phase1 polarity1 miso", 32'(mi[11:0]), 32'hABC);
        check(dma_rd_req == 1'b1, "R7 dma_rd phase1", 32'(dma_rd_req), 1);
        host_read();

        // R6 transmit-only, phase 1, polarity 0
        cfg_write(15'd0);
        cfg_write(mkcfg(1, 2'b10, 1, 0, 4'd7, 1, 1, 4'd0));
        pha_b = 1'b1; pol_b = 1'b0;
        tx_write(16'h0096);
        u0 = n_unf; o0 = n_ovf; e0 = n_eot;
        cs_low();
        push(16'h05A3, 0, 0);
        word(16'h00FF, 8, 0, mi);
        check(mi[7:0] == 8'h96, "R6 tx-only word sent", 32'(mi[7:0]), 32'h96);
        push(16'h05A3, 0, 0);
        word(16'h000F, 8, 0, mi);
        check(mi[7:0] == 8'h96, "R6 tx-only stale word", 32'(mi[7:0]), 32'h96);
        cs_high();
        check(n_eot == e0 + 2, "R6 eot still raised", n_eot - e0, 2);
        check(n_ovf == o0, "R6 no overflow", n_ovf - o0, 0);
        check(n_unf == u0 + 1, "R4 underflow tx-only", n_unf - u0, 1);
        check(rx_full == 1'b0 && dma_rd_req == 1'b0, "R6 rx side silent", 32'({rx_full, dma_rd_req}), 0);
        check(rx_data == 16'h05A3, "R6 rx_data unchanged", 32'(rx_data), 32'h05A3);
        check(dma_wr_req == 1'b1, "R7 dma_wr empty", 32'(dma_wr_req), 1);

        // R9 abort by select
        cfg_write(15'd0);
        cfg_write(mkcfg(1, 2'b00, 0, 0, 4'd7, 0, 0, 4'd0));
        pha_b = 1'b0; pol_b = 1'b0;
        tx_write(16'h006C);
        u0 = n_unf; e0 = n_eot;
        cs_low();
        word(16'h0005, 3, 0, mi);
        check(mi[2:0] == 3'b011, "R9 partial bits", 32'(mi[2:0]), 32'h3);
        cs_high();
        check(n_eot == e0, "R9 no eot on abort", n_eot - e0, 0);
        check(rx_full == 1'b0, "R9 no rx on abort", 32'(rx_full), 0);
        check(n_unf == u0, "R9 fresh load no underflow", n_unf - u0, 0);
        cs_low();
        push(16'h00D2, 0, 1);
        word(16'h00D2, 8, 0, mi);
        cs_high();
        check(mi[7:0] == 8'h6C, "R9 restart at first bit", 32'(mi[7:0]), 32'h6C);
        check(n_unf == u0 + 1, "R4 underflow after abort", n_unf - u0, 1);

        wait_h(4);
        check(exp_q.size() == 0, "R2 all words scored", 32'(exp_q.size()), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule